// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a SIMD integer datapath. It treats every 32-bit lane of a vector as an accumulator. For each lane it forms the dot product of small adjacent elements taken from two source vectors and adds it to that lane's accumulator value.

There are two element formats. In byte format, four unsigned bytes from A are multiplied by four signed bytes from B. In word format, two signed 16-bit words from A are multiplied by two signed 16-bit words from B. The final addition either wraps or clamps to the signed 32-bit range. A per-lane mask decides which lanes take the new value. A lane that the mask turns off either keeps its accumulator value or is forced to zero, as a separate select input chooses.

Operands enter through a valid/ready beat. The result appears on a registered output that holds its value until it is accepted. The number of active lanes is a parameter, 4 or 8. The output bus is always as wide as the largest configuration, and the bits above the active lanes are driven to zero.

Top module: `packed_dot_acc`

## Requirements
- R1: When in_op[0] is 0 (byte format), lane j reads bytes 4j..4j+3 of in_a and in_b, with byte 0 in bits 7:0. Each A byte is taken as unsigned and each B byte as signed. The lane result is the lane accumulator plus the four products.
- R2: When in_op[0] is 1 (word format), lane j reads 16-bit words 2j and 2j+1 of in_a and in_b, with word 0 in bits 15:0. Both words are taken as signed. The lane result is the accumulator plus the two products. Lane j of every vector occupies bits 32j+31:32j.
- R3: When in_op[1] is 0, the lane sum is reduced modulo 2^32.
- R4: When in_op[1] is 1, the exact sum of the accumulator and all products is clamped once to the range 0x80000000..0x7FFFFFFF. An intermediate partial sum that leaves this range does not cause a clamp if the final sum is inside it.
- R5: When in_zmask is 0 and in_mask[j] is 0, lane j of the result equals lane j of in_acc.
- R6: When in_zmask is 1 and in_mask[j] is 0, lane j of the result is zero. A lane whose mask bit is 1 carries the computed value in both masking modes.
- R7: Bits of out_data at or above LANES*32 are always zero.
- R8: in_ready is high whenever out_valid is low or out_ready is high. A beat accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high after that edge.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change. out_valid falls after an edge at which out_ready is high and no beat is accepted.
- R10: After reset, out_valid is low, out_data is zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_acc | input | LANES*32 | Per-lane 32-bit accumulators |
| in_a | input | LANES*32 | Source vector A (unsigned bytes or signed words) |
| in_b | input | LANES*32 | Source vector B (signed bytes or signed words) |
| in_op | input | 2 | Bit 0: 0 byte format, 1 word format. Bit 1: 0 wrap, 1 saturate |
| in_mask | input | LANES | Per-lane enable, bit j controls lane j |
| in_zmask | input | 1 | 0 keeps the accumulator in off lanes, 1 zeroes them |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | MAX_LANES*32 | Registered result vector |

## Verification
The assertions check the lane-level rules on every cycle. They cover the handshake relation between in_ready, out_valid and out_ready, and the fact that a stalled result stays unchanged. They also cover the zero upper bits, and that a lane switched off by the mask takes either the old accumulator or zero. The arithmetic needs scenarios to show it: the byte and word element placement, wrap against clamp, and clamping only on the final sum. The bench covers these with a vector table and with directed lane-placement cases checked against a behavioural model. Only the bench shows back-pressure with a competing beat waiting, the drop of out_valid after a drain, and the reset state.

// File: rtl/packed_dot_acc.sv
module packed_dot_acc #(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*32-1:0]       in_acc,
  input  logic [LANES*32-1:0]       in_a,
  input  logic [LANES*32-1:0]       in_b,
  input  logic [1:0]                in_op,
  input  logic [LANES-1:0]          in_mask,
  input  logic                      in_zmask,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [MAX_LANES*32-1:0]   out_data
);
  localparam int LW  = 32;
  localparam int AW  = LANES * LW;
  localparam int VW  = MAX_LANES * LW;
  localparam int BPL = LW / 8;
  localparam int WPL = LW / 16;
  localparam int SW  = 36;
  localparam logic signed [SW-1:0] SMAX = 36'sh07FFFFFFF;
  localparam logic signed [SW-1:0] SMIN = 36'shF80000000;

  logic [VW-1:0] res;
  logic          take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0]          acc, a, b, arith;
    logic signed [16:0]     pb [BPL];
    logic signed [31:0]     pw [WPL];
    logic signed [SW-1:0]   tot;

    assign acc = in_acc[g*LW +: LW];
    assign a   = in_a[g*LW +: LW];
    assign b   = in_b[g*LW +: LW];

    always_comb begin
      for (int k = 0; k < BPL; k++)
        pb[k] = $signed({9'd0, a[8*k +: 8]}) * $signed({{9{b[8*k+7]}}, b[8*k +: 8]});
      for (int k = 0; k < WPL; k++)
        pw[k] = $signed({{16{a[16*k+15]}}, a[16*k +: 16]}) *
                $signed({{16{b[16*k+15]}}, b[16*k +: 16]});
      tot = {{(SW-LW){acc[LW-1]}}, acc};
      if (!in_op[0]) begin
        for (int k = 0; k < BPL; k++)
          tot = tot + {{(SW-17){pb[k][16]}}, pb[k]};
      end else begin
        for (int k = 0; k < WPL; k++)
          tot = tot + {{(SW-32){pw[k][31]}}, pw[k]};
      end
    end

    always_comb begin
      if (in_op[1] && tot > SMAX)      arith = 32'h7FFF_FFFF;
      else if (in_op[1] && tot < SMIN) arith = 32'h8000_0000;
      else                             arith = tot[LW-1:0];
    end

    assign res[g*LW +: LW] = in_mask[g] ? arith : (in_zmask ? '0 : acc);
  end

  if (LANES < MAX_LANES) begin : g_pad
    assign res[VW-1:AW] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/packed_dot_acc_chk.sv
module packed_dot_acc_chk #(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LANES*32-1:0]     in_acc,
  input logic [LANES-1:0]        in_mask,
  input logic                    in_zmask,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [MAX_LANES*32-1:0] out_data
);
  localparam int AW = LANES * 32;
  localparam int VW = MAX_LANES * 32;

  p_ready_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  if (LANES < MAX_LANES) begin : g_up
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_data[VW-1:AW] == '0);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_l
    p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_mask[g] && !in_zmask)
        |=> out_data[g*32 +: 32] == $past(in_acc[g*32 +: 32]));

    p_zero_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_mask[g] && in_zmask)
        |=> out_data[g*32 +: 32] == 32'd0);
  end
endmodule

bind packed_dot_acc packed_dot_acc_chk #(.MAX_LANES(MAX_LANES), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_acc(in_acc), .in_mask(in_mask), .in_zmask(in_zmask),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_packed_dot_acc.sv
module tb_packed_dot_acc;
  localparam int MAX_LANES = 8;
  localparam int LANES     = 4;
  localparam int AW = LANES * 32;
  localparam int VW = MAX_LANES * 32;

  typedef struct packed {
    logic [1:0]  op;
    logic        zm;
    logic [7:0]  mask;
    logic [31:0] acc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp0;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 8'hFF, 32'h0000_0000, 32'h0403_0201, 32'h0101_0101, 32'h0000_000A},
    '{2'b00, 1'b0, 8'hFF, 32'h0000_0064, 32'hFFFF_FFFF, 32'h8080_8080, 32'hFFFE_0264},
    '{2'b01, 1'b0, 8'hFF, 32'h0000_0010, 32'h0003_0002, 32'hFFFF_0005, 32'h0000_0017},
    '{2'b01, 1'b0, 8'hFF, 32'h0000_0000, 32'h8000_8000, 32'h8000_8000, 32'h8000_0000},
    '{2'b11, 1'b0, 8'hFF, 32'h0000_0000, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF},
    '{2'b11, 1'b0, 8'hFF, 32'h8000_0000, 32'h8000_8000, 32'h7FFF_7FFF, 32'h8000_0000},
    '{2'b10, 1'b0, 8'hFF, 32'h7FFF_FFF0, 32'h0101_0101, 32'h0101_0101, 32'h7FFF_FFF4},
    '{2'b10, 1'b0, 8'hFF, 32'h7FFF_FFFF, 32'h0000_00FF, 32'h0000_007F, 32'h7FFF_FFFF},
    '{2'b00, 1'b0, 8'hFF, 32'h7FFF_FFFF, 32'h0000_00FF, 32'h0000_007F, 32'h8000_7E80},
    '{2'b11, 1'b0, 8'hFF, 32'h7FFF_0000, 32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_8000},
    '{2'b00, 1'b0, 8'h00, 32'h1234_5678, 32'h0403_0201, 32'h0101_0101, 32'h0000_0000},
    '{2'b00, 1'b1, 8'h00, 32'h1234_5678, 32'h0403_0201, 32'h0101_0101, 32'h0000_0000},
    '{2'b01, 1'b0, 8'h05, 32'h0000_0007, 32'h0003_0002, 32'hFFFF_0005, 32'h0000_000E},
    '{2'b10, 1'b1, 8'h0A, 32'hFFFF_FFF0, 32'h0000_0002, 32'h0000_00FE, 32'hFFFF_FFEC},
    '{2'b10, 1'b0, 8'hFF, 32'h8000_0000, 32'h0000_00FF, 32'h0000_0080, 32'h8000_0000}
  };
  localparam string TREQ [NV] = '{"R1 R3", "R1 R3", "R2 R3", "R2 R3", "R2 R4", "R2 R4",
    "R1 R4", "R1 R4", "R1 R3", "R2 R4", "R5", "R6", "R2 R5", "R1 R6", "R1 R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] in_acc = '0, in_a = '0, in_b = '0;
  logic [1:0] in_op = '0;
  logic [LANES-1:0] in_mask = '0;
  logic in_zmask = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [VW-1:0] out_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  packed_dot_acc #(.MAX_LANES(MAX_LANES), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .in_mask(in_mask), .in_zmask(in_zmask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_model(input logic [31:0] acc, input logic [31:0] a,
                                             input logic [31:0] b, input logic [1:0] op);
    longint s;
    s = longint'($signed(acc));
    if (!op[0]) begin
      for (int k = 0; k < 4; k++)
        s += longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
    end else begin
      for (int k = 0; k < 2; k++)
        s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
    end
    if (op[1] && s > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (op[1] && s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  task automatic send(input logic [AW-1:0] acc, input logic [AW-1:0] a, input logic [AW-1:0] b,
                      input logic [1:0] op, input logic zm, input logic [LANES-1:0] mask);
    @(negedge clk);
    in_acc = acc; in_a = a; in_b = b; in_op = op; in_zmask = zm; in_mask = mask;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] ev;
    logic [AW-1:0] va, vb, vc;
    logic [VW-1:0] held;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 out_valid", VW'(out_valid), VW'(0));
    check("R10 out_data", out_data, '0);
    check("R10 in_ready", VW'(in_ready), VW'(1));
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send({LANES{TBL[i].acc}}, {LANES{TBL[i].a}}, {LANES{TBL[i].b}},
           TBL[i].op, TBL[i].zm, TBL[i].mask[LANES-1:0]);
      ev = '0;
      for (int j = 0; j < LANES; j++)
        ev[32*j +: 32] = TBL[i].mask[j] ? TBL[i].exp0 : (TBL[i].zm ? 32'd0 : TBL[i].acc);
      check({"table ", TREQ[i]}, out_data, ev);
      check("R8 valid after accept", VW'(out_valid), VW'(1));
    end

    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < AW / 8; i++) begin
        va[8*i +: 8] = 8'(i * 37 + 11 + m * 50);
        vb[8*i +: 8] = (i % 2 == 1) ? 8'(8'h80 + i + m) : 8'(i * 5 + 1);
      end
      for (int j = 0; j < LANES; j++) vc[32*j +: 32] = 32'(j * 32'h0100_0000 + 32'h7FFF_F000 * m);
      if (m >= 2)
        for (int i = 0; i < AW / 16; i++) va[16*i +: 16] = 16'(16'h8000 + i * 1234 + m);
      send(vc, va, vb, 2'(m), 1'b0, '1);
      ev = '0;
      for (int j = 0; j < LANES; j++)
        ev[32*j +: 32] = lane_model(vc[32*j +: 32], va[32*j +: 32], vb[32*j +: 32], 2'(m));
      check((m % 2 == 0) ? "R1 lane placement" : "R2 lane placement", out_data, ev);
    end

    va = '1; vb = '1; vc = '1;
    send(vc, va, vb, 2'b00, 1'b0, '1);
    check("R7 upper bits zero", out_data >> AW, '0);

    @(negedge clk);
    out_ready = 1'b0;
    for (int j = 0; j < LANES; j++) vc[32*j +: 32] = 32'(j + 100);
    send(vc, {LANES{32'h0101_0101}}, {LANES{32'h0101_0101}}, 2'b00, 1'b0, '1);
    held = out_data;
    ev = '0;
    for (int j = 0; j < LANES; j++) ev[32*j +: 32] = 32'(j + 104);
    check("R8 stalled beat result", out_data, ev);
    check("R8 in_ready low when stalled", VW'(in_ready), VW'(0));
    in_acc = '0; in_op = 2'b01; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 data held", out_data, held);
    check("R9 valid held", VW'(out_valid), VW'(1));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ev = '0;
    for (int j = 0; j < LANES; j++)
      ev[32*j +: 32] = lane_model(32'd0, 32'h0101_0101, 32'h0101_0101, 2'b01);
    check("R8 waiting beat taken after release", out_data, ev);
    @(negedge clk);
    check("R9 valid drops after drain", VW'(out_valid), VW'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule